// File: doc/BRIEF.md
# Injected Group Discontinuous Sequencer

This block drives the channel selection for the injected group of an ADC. The group is a programmable list of up to four channel slots. In discontinuous mode each trigger converts a short run of n consecutive slots and then stops. The sequencer remembers where the run ended, so the next trigger carries on from that slot. When the run that reaches the last slot completes, the position wraps to slot 0. When discontinuous mode is off, a trigger converts the whole list starting from slot 0.

The analog converter sits outside the block. For each slot the sequencer puts the channel index on `ch_sel` and raises a one-cycle `soc` pulse. It then waits for the converter to pulse `conv_done`. Two sticky flags, one regular and one injected, report that a group has finished. An illegal mix of mode bits raises `cfg_err`, and while it is high every trigger is ignored.

Top module: `inj_disc_seq`

## Requirements
- R1: A low `rst_n` at a clock edge clears both flags, drops `soc` and returns the position to slot 0, so the next trigger starts at slot 0.
- R2: In discontinuous mode a trigger converts n = `run_len`+1 slots. Each slot produces one `soc` pulse, and `ch_sel` shows the slot's channel while that pulse is high. Slot i sits at bits [i*CH_W +: CH_W] of `ch_list`.
- R3: The position is kept between triggers. With n = 1 and a list of length 3, triggers 1, 2 and 3 convert slots 0, 1 and 2 in turn.
- R4: Once a run has converted its n slots, or has reached the last slot, no further `soc` is issued until the next trigger.
- R5: After the run that converts the last slot (index `grp_len`, so the list length is `grp_len`+1), the next trigger starts at slot 0.
- R6: `eoc_flag` and `jeoc_flag` are both set in the cycle after the `conv_done` of the last slot, and at no other time.
- R7: The flags are sticky. `flag_clr` bit 0 clears `eoc_flag` and bit 1 clears `jeoc_flag`. If a set and a clear fall on the same edge, the set wins.
- R8: A trigger that arrives while a run is in progress has no effect on that run, and it does not start another one.
- R9: When `auto_inj` and `disc_inj` are both high, `cfg_err` is high and triggers are ignored. The position is kept.
- R10: When `disc_inj` and `disc_reg` are both high, `cfg_err` is high and triggers are ignored.
- R11: With `disc_inj` low, a trigger converts every slot from slot 0 to the last slot and then sets both flags.
- R12: `soc` lasts exactly one cycle. The next `soc` comes only after a `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Conversion trigger, sampled in the idle state |
| conv_done | input | 1 | Converter finished the current slot |
| grp_len | input | SLOT_W | Index of the last slot (list length minus one) |
| ch_list | input | MAX_LEN*CH_W | Channel index for each slot, slot 0 in the low bits |
| run_len | input | RUN_W | Run length minus one (n-1) |
| auto_inj | input | 1 | Automatic injected mode requested |
| disc_inj | input | 1 | Discontinuous mode for the injected group |
| disc_reg | input | 1 | Discontinuous mode for the regular group |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 regular, bit 1 injected |
| ch_sel | output | CH_W | Channel of the current slot |
| soc | output | 1 | Start-conversion strobe |
| eoc_flag | output | 1 | Sticky regular end-of-conversion flag |
| jeoc_flag | output | 1 | Sticky injected end-of-conversion flag |
| cfg_err | output | 1 | Illegal mode combination |

## Verification
The bench sweeps every list length from 1 to 4 against every run length from 1 to 4, with enough triggers to wrap at least once. This catches truncation at the end of the group. A design that ignored it would run past the last slot into stale channels, or would start the next trigger somewhere other than slot 0. The flags are checked after every run, because a design that raised them at the end of each run, and not only at the end of the group, would report finished groups that are not finished.

Further targeted cases cover the following:
- Retriggering mid-run. A wrong design would restart the run or stretch it.
- A clear and a set landing on the same edge. A wrong design would lose the group-end event.
- Both illegal mode pairs. A wrong design would convert while misconfigured, or lose its position.
- Reset partway through a group.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SOC  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_t;

   localparam int FLAG_REG = 0;
   localparam int FLAG_INJ = 1;
   localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/seq_cfg_guard.sv
module seq_cfg_guard (
   input  logic auto_inj,
   input  logic disc_inj,
   input  logic disc_reg,
   output logic cfg_err
);
   logic auto_clash;
   logic disc_clash;

   always_comb begin
      auto_clash = auto_inj & disc_inj;
      disc_clash = disc_inj & disc_reg;
      cfg_err    = auto_clash | disc_clash;
   end
endmodule

// File: rtl/seq_ch_mux.sv
module seq_ch_mux #(
   parameter int MAX_LEN = 4,
   parameter int CH_W    = 5,
   parameter int SLOT_W  = 2
) (
   input  logic [MAX_LEN*CH_W-1:0] ch_list,
   input  logic [SLOT_W-1:0]       pos,
   output logic [CH_W-1:0]         ch_sel
);
   logic [CH_W-1:0] slots [MAX_LEN];

   generate
      for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
         assign slots[g] = ch_list[g*CH_W +: CH_W];
      end
   endgenerate

   always_comb begin
      ch_sel = '0;
      for (int i = 0; i < MAX_LEN; i++) begin
         if (pos == SLOT_W'(i)) ch_sel = slots[i];
      end
   end
endmodule

// File: rtl/seq_cursor.sv
module seq_cursor #(
   parameter int SLOT_W = 2,
   parameter int RUN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_start,
   input  logic              advance,
   input  logic              disc,
   input  logic [SLOT_W-1:0] grp_last,
   input  logic [RUN_W-1:0]  run_last,
   output logic [SLOT_W-1:0] pos,
   output logic              end_run,
   output logic              end_group
);
   logic [RUN_W-1:0] cnt;
   logic             last_slot;
   logic             last_run;

   always_comb begin
      last_slot = (pos >= grp_last);
      last_run  = disc & (cnt >= run_last);
      end_group = advance & last_slot;
      end_run   = advance & (last_slot | last_run);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
         cnt <= '0;
      end else if (run_start) begin
         cnt <= '0;
         if (!disc) pos <= '0;
      end else if (advance) begin
         cnt <= cnt + RUN_W'(1);
         pos <= last_slot ? '0 : pos + SLOT_W'(1);
      end
   end

   // R5
   wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_group |=> (pos == '0));

   // R3
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && (disc || !run_start)) |=> $stable(pos));
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flag
);
   generate
      for (genvar g = 0; g < NF; g++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
         end

         // R7
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flag[g]);

         // R7
         clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set[g]) |=> !flag[g]);
      end
   endgenerate
endmodule

// File: rtl/inj_disc_seq.sv
module inj_disc_seq
   import inj_seq_pkg::*;
#(
   parameter int MAX_LEN = 4,
   parameter int CH_W    = 5,
   parameter int RUN_W   = 3,
   localparam int SLOT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig,
   input  logic                    conv_done,
   input  logic [SLOT_W-1:0]       grp_len,
   input  logic [MAX_LEN*CH_W-1:0] ch_list,
   input  logic [RUN_W-1:0]        run_len,
   input  logic                    auto_inj,
   input  logic                    disc_inj,
   input  logic                    disc_reg,
   input  logic [1:0]              flag_clr,
   output logic [CH_W-1:0]         ch_sel,
   output logic                    soc,
   output logic                    eoc_flag,
   output logic                    jeoc_flag,
   output logic                    cfg_err
);
   generate
      if (MAX_LEN < 1 || MAX_LEN > 16) begin : g_bad_len
         $error("MAX_LEN must lie in 1..16");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("CH_W must be at least 1");
      end
      if (RUN_W < 1) begin : g_bad_run
         $error("RUN_W must be at least 1");
      end
   endgenerate

   sq_state_t               state, state_nx;
   logic [SLOT_W-1:0]       pos;
   logic                    run_start;
   logic                    advance;
   logic                    end_run;
   logic                    end_group;
   logic [NUM_FLAGS-1:0]    flag_set;
   logic [NUM_FLAGS-1:0]    flag_q;

   seq_cfg_guard i_guard (
      .auto_inj (auto_inj),
      .disc_inj (disc_inj),
      .disc_reg (disc_reg),
      .cfg_err  (cfg_err)
   );

   always_comb begin
      run_start = (state == SQ_IDLE) && trig && !cfg_err;
      advance   = (state == SQ_WAIT) && conv_done;
      state_nx  = state;
      case (state)
         SQ_IDLE: if (run_start) state_nx = SQ_SOC;
         SQ_SOC:  state_nx = SQ_WAIT;
         SQ_WAIT: if (advance) state_nx = end_run ? SQ_IDLE : SQ_SOC;
         default: state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SQ_IDLE;
      else        state <= state_nx;
   end

   seq_cursor #(.SLOT_W(SLOT_W), .RUN_W(RUN_W)) i_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_start (run_start),
      .advance   (advance),
      .disc      (disc_inj),
      .grp_last  (grp_len),
      .run_last  (run_len),
      .pos       (pos),
      .end_run   (end_run),
      .end_group (end_group)
   );

   seq_ch_mux #(.MAX_LEN(MAX_LEN), .CH_W(CH_W), .SLOT_W(SLOT_W)) i_mux (
      .ch_list (ch_list),
      .pos     (pos),
      .ch_sel  (ch_sel)
   );

   assign flag_set = {NUM_FLAGS{end_group}};

   seq_flags #(.NF(NUM_FLAGS)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flag  (flag_q)
   );

   assign eoc_flag  = flag_q[FLAG_REG];
   assign jeoc_flag = flag_q[FLAG_INJ];
   assign soc       = (state == SQ_SOC);

   // R12
   soc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soc |=> !soc);

   // R9
   cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && cfg_err) |=> !soc);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WAIT && !conv_done) |=> (state == SQ_WAIT && $stable(pos)));

   // R6
   flag_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jeoc_flag) |-> $past(end_group));
endmodule

// File: tb/test_inj_disc_seq.sv
module test_inj_disc_seq;
   localparam int MAX_LEN = 4;
   localparam int CH_W    = 5;
   localparam int RUN_W   = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                    rst_n = 1'b0;
   logic                    trig = 1'b0;
   logic                    conv_done = 1'b0;
   logic [1:0]              grp_len = 2'd0;
   logic [MAX_LEN*CH_W-1:0] ch_list;
   logic [RUN_W-1:0]        run_len = '0;
   logic                    auto_inj = 1'b0;
   logic                    disc_inj = 1'b1;
   logic                    disc_reg = 1'b0;
   logic [1:0]              flag_clr = 2'b00;
   logic [CH_W-1:0]         ch_sel;
   logic                    soc, eoc_flag, jeoc_flag, cfg_err;

   int n_chk  = 0;
   int n_fail = 0;
   int mpos   = 0;

   inj_disc_seq #(.MAX_LEN(MAX_LEN), .CH_W(CH_W), .RUN_W(RUN_W)) i_inj_disc_seq (
      .clk(clk), .rst_n(rst_n), .trig(trig), .conv_done(conv_done),
      .grp_len(grp_len), .ch_list(ch_list), .run_len(run_len),
      .auto_inj(auto_inj), .disc_inj(disc_inj), .disc_reg(disc_reg),
      .flag_clr(flag_clr), .ch_sel(ch_sel), .soc(soc),
      .eoc_flag(eoc_flag), .jeoc_flag(jeoc_flag), .cfg_err(cfg_err)
   );

   function automatic logic [CH_W-1:0] slot_ch(int i);
      return CH_W'(3 * i + 7);
   endfunction

   initial begin
      for (int i = 0; i < MAX_LEN; i++) ch_list[i*CH_W +: CH_W] = slot_ch(i);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mpos = 0;
   endtask

   task automatic clear_flags();
      flag_clr = 2'b11;
      @(negedge clk);
      flag_clr = 2'b00;
      check(eoc_flag == 1'b0, "R7 regular flag cleared", eoc_flag, 0);
      check(jeoc_flag == 1'b0, "R7 injected flag cleared", jeoc_flag, 0);
   endtask

   task automatic run_trigger(input int len, input int n, input bit disc,
                              input bit retrig, input bit hold_clr);
      int start, cnt;
      bit last;
      start = disc ? mpos : 0;
      cnt   = disc ? (((len - start) < n) ? (len - start) : n) : len;
      last  = (start + cnt == len);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      flag_clr = hold_clr ? 2'b11 : 2'b00;
      for (int k = 0; k < cnt; k++) begin
         int w;
         w = 0;
         while (!soc && w < 12) begin
            @(negedge clk);
            w++;
         end
         check(soc == 1'b1, "R2 start strobe issued", soc, 1);
         check(ch_sel == slot_ch(start + k), "R3 channel order", ch_sel, slot_ch(start + k));
         trig = retrig;
         @(negedge clk);
         check(soc == 1'b0, "R12 strobe lasts one cycle", soc, 0);
         conv_done = 1'b1;
         trig = retrig;
         @(negedge clk);
         conv_done = 1'b0;
         trig = 1'b0;
         if (k == cnt - 1) begin
            flag_clr = 2'b00;
            check(eoc_flag == last, "R6 regular flag at group end", eoc_flag, last);
            check(jeoc_flag == last, "R6 injected flag at group end", jeoc_flag, last);
         end
      end
      for (int w = 0; w < 5; w++) begin
         check(soc == 1'b0, "R4 run stops after n or group end", soc, 0);
         @(negedge clk);
      end
      mpos = last ? 0 : start + cnt;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      check(soc == 1'b0, "R1 no strobe after reset", soc, 0);
      check(eoc_flag == 1'b0 && jeoc_flag == 1'b0, "R1 flags clear after reset",
            {eoc_flag, jeoc_flag}, 0);

      // R2 R3 R4 R5 R6: sweep of list length against run length
      for (int len = 1; len <= MAX_LEN; len++) begin
         for (int n = 1; n <= 4; n++) begin
            grp_len = 2'(len - 1);
            run_len = RUN_W'(n - 1);
            disc_inj = 1'b1;
            do_reset();
            for (int t = 0; t < len + 2; t++) begin
               run_trigger(len, n, 1'b1, 1'b0, 1'b0);
               clear_flags();
            end
         end
      end

      // R8: retrigger during a run, list of 4, n = 3
      grp_len = 2'd3; run_len = 3'd2;
      do_reset();
      run_trigger(4, 3, 1'b1, 1'b1, 1'b0);
      run_trigger(4, 3, 1'b1, 1'b1, 1'b0);
      clear_flags();

      // R7: set wins over a held clear; then bitwise clear
      grp_len = 2'd2; run_len = 3'd0;
      do_reset();
      run_trigger(3, 1, 1'b1, 1'b0, 1'b0);
      run_trigger(3, 1, 1'b1, 1'b0, 1'b0);
      run_trigger(3, 1, 1'b1, 1'b0, 1'b1);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      check(eoc_flag == 1'b0, "R7 bit 0 clears regular flag", eoc_flag, 0);
      check(jeoc_flag == 1'b1, "R7 bit 0 leaves injected flag", jeoc_flag, 1);
      flag_clr = 2'b10;
      @(negedge clk);
      flag_clr = 2'b00;
      check(jeoc_flag == 1'b0, "R7 bit 1 clears injected flag", jeoc_flag, 0);

      // R9: automatic plus discontinuous
      grp_len = 2'd3; run_len = 3'd0;
      do_reset();
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);
      auto_inj = 1'b1;
      @(negedge clk);
      check(cfg_err == 1'b1, "R9 error on auto with discontinuous", cfg_err, 1);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      for (int w = 0; w < 6; w++) begin
         check(soc == 1'b0, "R9 trigger ignored on error", soc, 0);
         @(negedge clk);
      end
      auto_inj = 1'b0;
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 error gone when legal", cfg_err, 0);
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);

      // R10: both groups discontinuous
      disc_reg = 1'b1;
      @(negedge clk);
      check(cfg_err == 1'b1, "R10 error on both groups", cfg_err, 1);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      for (int w = 0; w < 6; w++) begin
         check(soc == 1'b0, "R10 trigger ignored on error", soc, 0);
         @(negedge clk);
      end
      disc_reg = 1'b0;
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);

      // R11: discontinuous off converts the whole list from slot 0
      disc_inj = 1'b0;
      auto_inj = 1'b1;
      @(negedge clk);
      check(cfg_err == 1'b0, "R11 auto alone is legal", cfg_err, 0);
      run_trigger(4, 1, 1'b0, 1'b0, 1'b0);
      clear_flags();
      auto_inj = 1'b0;
      disc_inj = 1'b1;

      // R1: reset partway through the group
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);
      do_reset();
      check(eoc_flag == 1'b0 && jeoc_flag == 1'b0, "R1 flags after mid reset",
            {eoc_flag, jeoc_flag}, 0);
      run_trigger(4, 1, 1'b1, 1'b0, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule